// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Controller

This block is the control unit of a small accumulator machine, together with the few datapath registers it drives. A 2-bit phase register selects one of four phases, and a step counter numbers the cycles inside the current phase. For every phase and step, a combinational decoder asserts a fixed set of register-transfer strobes. These strobes move data between the program counter, the memory address register, the memory buffer register, the instruction register and the accumulator. They also drive a read or write strobe toward memory. One shared +1 unit serves every increment.

An instruction word is 16 bits. Bits 15:13 hold the opcode, bit 12 is the indirect flag and bits 11:0 are the address. Memory sits outside the block. A write is committed at the clock edge while `mem_we` is high. Read data must be valid on `mem_rdata` during the cycle in which `mem_re` is high, for the address on `mem_addr`.

Top module: `cyc_ctrl_top`

## Requirements
- R1: A synchronous reset leaves phase 2'b00 (fetch), step 1, PC 0, accumulator 0 and interrupt enable 0.
- R2: Fetch lasts three cycles. In its second cycle `mem_re` is high with `mem_addr` equal to PC, and PC increments. After the third cycle the instruction register holds the word that was read.
- R3: After fetch, the phase becomes 2'b01 (indirect) if bit 12 of the fetched word is set, and 2'b10 (execute) otherwise. The step counter returns to 1 on every phase change, and a completed instruction ends in phase 2'b00, step 1.
- R4: The indirect phase lasts three cycles. It reads the word at the address in instruction bits 11:0 and replaces only those 12 bits with bits 11:0 of that word. Opcode and flag are kept, and the phase then becomes execute.
- R5: Opcode 3'b001 executes in three cycles and sets the accumulator to accumulator + memory[address], modulo 2^16.
- R6: Opcode 3'b010 executes in four cycles. In the fourth cycle it writes memory[address]+1 (mod 2^16) back to that address. If that value is zero, PC is incremented once more in the same cycle.
- R7: Opcode 3'b011 executes in three cycles. It stores the current PC, zero-extended, at the address, and leaves PC equal to address+1.
- R8: Opcode 3'b100 sets the interrupt enable in a one-cycle execute. Opcodes 3'b000, 3'b101, 3'b110 and 3'b111 take a one-cycle execute that writes no memory and changes neither the accumulator nor PC.
- R9: At the end of execute the phase becomes 2'b11 (interrupt) only if `irq` is high and the enable was already set before that cycle. Otherwise it becomes fetch, so `irq` has no effect while the enable is clear.
- R10: Interrupt entry lasts three cycles. It writes PC to SAVE_ADDR, sets PC to ISR_ADDR, clears the enable and returns to fetch.
- R11: `mem_we` and `mem_re` are never high in the same cycle, and write data always comes from the memory buffer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Read data for `mem_addr` |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_wdata | output | 16 | Write data (MBR) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| phase_o | output | 2 | Phase code |
| step_o | output | 3 | Step within phase, from 1 |
| ien_o | output | 1 | Interrupt enable |

## Verification
In the last step of increment-and-skip, the memory write-back and the conditional PC increment fall in the same cycle. Both depend on the buffer value that the previous step produced. The bench sweeps operands across the wrap from 0xFFFD to 0x0000. It judges the cycle by both the stored word and the extra PC step, which must appear exactly when the stored word is zero. The branch-and-save step, in which PC is loaded and memory is written at once, is judged the same way through the saved return address and the resulting PC.

// File: rtl/cyc_ctrl_pkg.sv
package cyc_ctrl_pkg;

    localparam int OPC_W  = 3;
    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_INDIR = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    localparam logic [OPC_W-1:0] OP_ADD = 3'd1;
    localparam logic [OPC_W-1:0] OP_ISZ = 3'd2;
    localparam logic [OPC_W-1:0] OP_BSA = 3'd3;
    localparam logic [OPC_W-1:0] OP_ION = 3'd4;

    // datapath strobes for one step
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mar_from_save;
        logic mbr_from_mem;
        logic mbr_from_pc;
        logic mbr_inc;
        logic pc_inc;
        logic pc_inc_if_zero;
        logic pc_from_ir;
        logic pc_from_isr;
        logic ir_from_mbr;
        logic iraddr_from_mbr;
        logic ac_add;
        logic mem_rd;
        logic mem_wr;
    } dp_ctl_t;

    // sequencing strobes for one step
    typedef struct packed {
        logic last;
        logic ien_set;
        logic ien_clr;
    } sq_ctl_t;

    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
        logic              ien;
    } seq_st_t;

endpackage

// File: rtl/cyc_incr.sv
module cyc_incr #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    assign y = a + W'(1);
endmodule

// File: rtl/cyc_decode.sv
module cyc_decode
    import cyc_ctrl_pkg::*;
(
    input  phase_e                   phase,
    input  logic [STEP_W-1:0]        step,
    input  logic [OPC_W-1:0]         opcode,
    output dp_ctl_t                  dp,
    output sq_ctl_t                  sq
);
    always_comb begin
        dp = '0;
        sq = '0;
        unique case (phase)
            PH_FETCH: begin
                case (step)
                    3'd1:    dp.mar_from_pc = 1'b1;
                    3'd2:    begin dp.mem_rd = 1'b1; dp.mbr_from_mem = 1'b1; dp.pc_inc = 1'b1; end
                    default: begin dp.ir_from_mbr = 1'b1; sq.last = 1'b1; end
                endcase
            end
            PH_INDIR: begin
                case (step)
                    3'd1:    dp.mar_from_ir = 1'b1;
                    3'd2:    begin dp.mem_rd = 1'b1; dp.mbr_from_mem = 1'b1; end
                    default: begin dp.iraddr_from_mbr = 1'b1; sq.last = 1'b1; end
                endcase
            end
            PH_EXEC: begin
                case (opcode)
                    OP_ADD: begin
                        case (step)
                            3'd1:    dp.mar_from_ir = 1'b1;
                            3'd2:    begin dp.mem_rd = 1'b1; dp.mbr_from_mem = 1'b1; end
                            default: begin dp.ac_add = 1'b1; sq.last = 1'b1; end
                        endcase
                    end
                    OP_ISZ: begin
                        case (step)
                            3'd1:    dp.mar_from_ir = 1'b1;
                            3'd2:    begin dp.mem_rd = 1'b1; dp.mbr_from_mem = 1'b1; end
                            3'd3:    dp.mbr_inc = 1'b1;
                            default: begin dp.mem_wr = 1'b1; dp.pc_inc_if_zero = 1'b1; sq.last = 1'b1; end
                        endcase
                    end
                    OP_BSA: begin
                        case (step)
                            3'd1:    begin dp.mar_from_ir = 1'b1; dp.mbr_from_pc = 1'b1; end
                            3'd2:    begin dp.pc_from_ir = 1'b1; dp.mem_wr = 1'b1; end
                            default: begin dp.pc_inc = 1'b1; sq.last = 1'b1; end
                        endcase
                    end
                    OP_ION: begin
                        sq.ien_set = 1'b1;
                        sq.last    = 1'b1;
                    end
                    default: sq.last = 1'b1;
                endcase
            end
            default: begin
                case (step)
                    3'd1:    dp.mbr_from_pc = 1'b1;
                    3'd2:    begin dp.mar_from_save = 1'b1; dp.pc_from_isr = 1'b1; end
                    default: begin dp.mem_wr = 1'b1; sq.ien_clr = 1'b1; sq.last = 1'b1; end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/cyc_seq.sv
module cyc_seq
    import cyc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq,
    input  logic              ind_bit,
    input  sq_ctl_t           sq,
    output phase_e            phase,
    output logic [STEP_W-1:0] step,
    output logic              ien
);
    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sq.ien_set) st_d.ien = 1'b1;
        if (sq.ien_clr) st_d.ien = 1'b0;
        if (sq.last) begin
            st_d.step = STEP_W'(1);
            unique case (st_q.phase)
                PH_FETCH: st_d.phase = ind_bit ? PH_INDIR : PH_EXEC;
                PH_INDIR: st_d.phase = PH_EXEC;
                PH_EXEC:  st_d.phase = (irq && st_q.ien) ? PH_INTR : PH_FETCH;
                default:  st_d.phase = PH_FETCH;
            endcase
        end else begin
            st_d.step = st_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_FETCH;
            st_q.step  <= STEP_W'(1);
            st_q.ien   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign step  = st_q.step;
    assign ien   = st_q.ien;
endmodule

// File: rtl/cyc_datapath.sv
module cyc_datapath
    import cyc_ctrl_pkg::*;
#(
    parameter int           AW        = 12,
    parameter logic [AW-1:0] SAVE_ADDR = 12'hF00,
    parameter logic [AW-1:0] ISR_ADDR  = 12'hE00,
    localparam int          DW        = OPC_W + 1 + AW
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_ctl_t          dp,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we,
    output logic             mem_re,
    output logic [AW-1:0]    pc,
    output logic [DW-1:0]    ac,
    output logic [DW-1:0]    ir,
    output logic [OPC_W-1:0] opcode,
    output logic             mbr_ind
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [DW-1:0] ir;
        logic [DW-1:0] ac;
    } dp_st_t;

    dp_st_t        r_d, r_q;
    logic [DW-1:0] inc_a, inc_y;

    assign inc_a = dp.mbr_inc ? r_q.mbr : {{(DW-AW){1'b0}}, r_q.pc};

    cyc_incr #(.W(DW)) u_incr (.a(inc_a), .y(inc_y));

    always_comb begin
        r_d = r_q;
        if (dp.mar_from_pc)   r_d.mar = r_q.pc;
        if (dp.mar_from_ir)   r_d.mar = r_q.ir[AW-1:0];
        if (dp.mar_from_save) r_d.mar = SAVE_ADDR;
        if (dp.mbr_from_mem)  r_d.mbr = mem_rdata;
        if (dp.mbr_from_pc)   r_d.mbr = {{(DW-AW){1'b0}}, r_q.pc};
        if (dp.mbr_inc)       r_d.mbr = inc_y;
        if (dp.pc_inc || (dp.pc_inc_if_zero && r_q.mbr == '0))
            r_d.pc = inc_y[AW-1:0];
        if (dp.pc_from_ir)    r_d.pc = r_q.ir[AW-1:0];
        if (dp.pc_from_isr)   r_d.pc = ISR_ADDR;
        if (dp.ir_from_mbr)   r_d.ir = r_q.mbr;
        if (dp.iraddr_from_mbr) r_d.ir[AW-1:0] = r_q.mbr[AW-1:0];
        if (dp.ac_add)        r_d.ac = r_q.ac + r_q.mbr;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign mem_addr  = r_q.mar;
    assign mem_wdata = r_q.mbr;
    assign mem_we    = dp.mem_wr;
    assign mem_re    = dp.mem_rd;
    assign pc        = r_q.pc;
    assign ac        = r_q.ac;
    assign ir        = r_q.ir;
    assign opcode    = r_q.ir[DW-1 -: OPC_W];
    assign mbr_ind   = r_q.mbr[AW];
endmodule

// File: rtl/cyc_ctrl_top.sv
module cyc_ctrl_top
    import cyc_ctrl_pkg::*;
#(
    parameter int            AW        = 12,
    parameter logic [AW-1:0] SAVE_ADDR = 12'hF00,
    parameter logic [AW-1:0] ISR_ADDR  = 12'hE00,
    localparam int           DW        = OPC_W + 1 + AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq,
    input  logic [DW-1:0]     mem_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [AW-1:0]     pc_o,
    output logic [DW-1:0]     ac_o,
    output logic [DW-1:0]     ir_o,
    output logic [1:0]        phase_o,
    output logic [STEP_W-1:0] step_o,
    output logic              ien_o
);
    dp_ctl_t          dp;
    sq_ctl_t          sq;
    phase_e           phase;
    logic [OPC_W-1:0] opcode;
    logic             mbr_ind;

    cyc_decode u_decode (
        .phase  (phase),
        .step   (step_o),
        .opcode (opcode),
        .dp     (dp),
        .sq     (sq)
    );

    cyc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .irq     (irq),
        .ind_bit (mbr_ind),
        .sq      (sq),
        .phase   (phase),
        .step    (step_o),
        .ien     (ien_o)
    );

    cyc_datapath #(.AW(AW), .SAVE_ADDR(SAVE_ADDR), .ISR_ADDR(ISR_ADDR)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .dp        (dp),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .pc        (pc_o),
        .ac        (ac_o),
        .ir        (ir_o),
        .opcode    (opcode),
        .mbr_ind   (mbr_ind)
    );

    assign phase_o = phase;
endmodule

// File: rtl/cyc_ctrl_chk.sv
module cyc_ctrl_chk #(
    parameter int            AW       = 12,
    parameter logic [AW-1:0] ISR_ADDR = 12'hE00
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    phase_o,
    input logic [2:0]    step_o,
    input logic          ien_o,
    input logic [AW-1:0] pc_o,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re
);
    a_r11_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r2_fetch_reads_pc: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b00 && step_o == 3'd2) |-> (mem_re && mem_addr == pc_o));

    a_r3_step_restarts: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |-> (step_o == 3'd1));

    a_r3_step_in_range: assert property (@(posedge clk) disable iff (rst)
        (step_o >= 3'd1 && step_o <= 3'd4));

    a_r9_intr_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b11 && step_o == 3'd1) |-> ien_o);

    a_r10_intr_exit: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b11 && step_o == 3'd3) |=> (!ien_o && pc_o == ISR_ADDR && phase_o == 2'b00));
endmodule

bind cyc_ctrl_top cyc_ctrl_chk #(.AW(AW), .ISR_ADDR(ISR_ADDR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase_o  (phase_o),
    .step_o   (step_o),
    .ien_o    (ien_o),
    .pc_o     (pc_o),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_re   (mem_re)
);

// File: tb/cyc_ctrl_top_bench.sv
module cyc_ctrl_top_bench;
    localparam logic [11:0] SAVE = 12'hF00;
    localparam logic [11:0] ISR  = 12'hE00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata, mem_wdata, ac_o, ir_o;
    logic [11:0] mem_addr, pc_o;
    logic        mem_we, mem_re, ien_o;
    logic [1:0]  phase_o;
    logic [2:0]  step_o;

    logic [15:0] mem [0:4095];
    int n_chk = 0, n_fail = 0, wr_cnt = 0, clash = 0;
    logic [11:0] mpc;
    logic [15:0] mac;

    always #10 clk = ~clk;

    cyc_ctrl_top #(.SAVE_ADDR(SAVE), .ISR_ADDR(ISR)) u_cyc_ctrl_top (
        .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .pc_o(pc_o), .ac_o(ac_o), .ir_o(ir_o), .phase_o(phase_o), .step_o(step_o), .ien_o(ien_o)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    always @(negedge clk) if (!rst) begin
        if (mem_we && mem_re) clash++;
        if (mem_we) wr_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // place word at model PC and run ncyc cycles; checks R2 and R3 on the way
    task automatic run(input logic [15:0] iw, input int ncyc);
        logic [1:0] ph_exp;
        ph_exp = iw[12] ? 2'b01 : 2'b10;
        mem[mpc] = iw;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            if (c == 1) chk(mem_re && mem_addr == mpc, "R2 fetch read at PC", {20'd0, mem_addr}, {20'd0, mpc});
            if (c == 3) chk(phase_o == ph_exp && step_o == 3'd1, "R3 phase after fetch",
                            {27'd0, phase_o, step_o}, {27'd0, ph_exp, 3'd1});
        end
        chk(phase_o == 2'b00 && step_o == 3'd1, "R3 back to fetch step 1",
            {27'd0, phase_o, step_o}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(phase_o == 2'b00 && step_o == 3'd1, "R1 reset phase/step", {27'd0, phase_o, step_o}, 32'd1);
        chk(pc_o == 12'd0 && ac_o == 16'd0 && !ien_o, "R1 reset pc/ac/ien", {pc_o, ac_o, 3'd0, ien_o}, 32'd0);
        mpc = 12'd0; mac = 16'd0;

        // R5: ADD sweep with wrapping sums
        for (int i = 0; i < 12; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h1357 + 16'h0F0F);
            mem[12'h100 + 12'(i)] = v;
            run({3'd1, 1'b0, 12'h100 + 12'(i)}, 6);
            mpc = mpc + 12'd1; mac = mac + v;
            chk(ac_o == mac, "R5 add result", {16'd0, ac_o}, {16'd0, mac});
            chk(pc_o == mpc, "R2 pc advanced", {20'd0, pc_o}, {20'd0, mpc});
        end

        // R4: indirect add, pointer upper bits must be dropped
        mem[12'h200] = 16'hF300;
        mem[12'h300] = 16'h4321;
        run({3'd1, 1'b1, 12'h200}, 9);
        mpc = mpc + 12'd1; mac = mac + 16'h4321;
        chk(ir_o == {3'd1, 1'b1, 12'h300}, "R4 ir address replaced", {16'd0, ir_o}, {16'd0, 3'd1, 1'b1, 12'h300});
        chk(ac_o == mac, "R4 R5 indirect add", {16'd0, ac_o}, {16'd0, mac});

        // R6: increment and skip across the wrap
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v, r;
            v = 16'hFFFD + 16'(k);
            r = v + 16'd1;
            mem[12'h180 + 12'(k)] = v;
            run({3'd2, 1'b0, 12'h180 + 12'(k)}, 7);
            mpc = mpc + ((r == 16'd0) ? 12'd2 : 12'd1);
            chk(mem[12'h180 + 12'(k)] == r, "R6 write back", {16'd0, mem[12'h180 + 12'(k)]}, {16'd0, r});
            chk(pc_o == mpc, "R6 skip on zero", {20'd0, pc_o}, {20'd0, mpc});
        end

        // R7: branch and save
        run({3'd3, 1'b0, 12'h500}, 6);
        chk(mem[12'h500] == {4'd0, mpc + 12'd1}, "R7 saved return", {16'd0, mem[12'h500]}, {20'd0, mpc + 12'd1});
        mpc = 12'h501;
        chk(pc_o == mpc, "R7 pc target+1", {20'd0, pc_o}, {20'd0, mpc});

        // R8: no-op opcodes
        for (int op = 0; op < 8; op++) begin
            int w0;
            if (op >= 1 && op <= 4) continue;
            w0 = wr_cnt;
            run({3'(op), 1'b0, 12'h123}, 4);
            mpc = mpc + 12'd1;
            chk(ac_o == mac && pc_o == mpc, "R8 no-op leaves ac/pc", {pc_o, ac_o, 4'd0}, {mpc, mac, 4'd0});
            chk(wr_cnt == w0, "R8 no-op writes nothing", wr_cnt, w0);
        end

        // R9: irq ignored while enable clear
        irq = 1'b1;
        mem[12'h110] = 16'h0001;
        run({3'd1, 1'b0, 12'h110}, 6);
        mpc = mpc + 12'd1; mac = mac + 16'd1;
        chk(pc_o == mpc && ac_o == mac, "R9 irq ignored", {pc_o, ac_o, 4'd0}, {mpc, mac, 4'd0});

        // R8 R9: enable instruction, its own end still goes to fetch
        run({3'd4, 1'b0, 12'h000}, 4);
        mpc = mpc + 12'd1;
        chk(ien_o == 1'b1, "R8 enable set", {31'd0, ien_o}, 32'd1);
        chk(pc_o == mpc, "R9 no entry on enabling cycle", {20'd0, pc_o}, {20'd0, mpc});

        // R10: interrupt entry after a no-op
        run({3'd0, 1'b0, 12'h000}, 7);
        irq = 1'b0;
        chk(mem[SAVE] == {4'd0, mpc + 12'd1}, "R10 pc saved", {16'd0, mem[SAVE]}, {20'd0, mpc + 12'd1});
        chk(pc_o == ISR && !ien_o, "R10 vector and enable cleared", {19'd0, pc_o, ien_o}, {19'd0, ISR, 1'b0});
        mpc = ISR;

        mem[12'h111] = 16'h0010;
        run({3'd1, 1'b0, 12'h111}, 6);
        mpc = mpc + 12'd1; mac = mac + 16'h0010;
        chk(pc_o == mpc && ac_o == mac, "R10 resumes at service address", {pc_o, ac_o, 4'd0}, {mpc, mac, 4'd0});

        chk(clash == 0, "R11 read and write never together", clash, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule